// File: doc/BRIEF.md
# Dual-Clock Command Mailbox Pair

The block carries short command words between two independently clocked ports. It holds two single-word registers. The first one is loaded from port A and read at port B. The second one is loaded from port B and read at port A. Each register has a "vacant" flag. The loading port drives the flag low when it stores a word. The other port drives it high again when it reads that word. The store and the release come from different clock domains. Each side therefore keeps a toggle bit, and the opposite domain learns of a change through a chain of synchronizer flops.

A store while the word is still unread is dropped. Reading leaves the stored word untouched. Each side sees both flags in its own clock domain.

The block also forms the data-output selection for both ports and the output-enable condition. Port A always presents the word from port B. Port B presents the word from port A when its mailbox select is high. When the select is low, port B presents the queue output word supplied from outside.

Top module: `mbx_pair`

## Requirements
- R1: A port-A access with chip select low, enable high, write/read high and mailbox select high on a `clk_a` edge stores `a_din` into the A-to-B word, provided `m1_vac_a` is high. After that edge `m1_vac_a` reads low. Port B mirrors this: the same access on a `clk_b` edge stores `b_din` into the B-to-A word and drives `m2_vac_b` low.
- R2: While a writer's vacant flag reads low, a further mailbox store from that writer leaves the stored word unchanged.
- R3: The reader's view of a new word (`m1_vac_b` for the A-to-B word, `m2_vac_a` for the B-to-A word) stays high until at least two reader-clock edges have passed after the store. It is low by the third reader edge, and it stays low until the reader reads the word.
- R4: A read with chip select low, enable high, write/read low and mailbox select high sets the reader's view high after that edge, provided that view was low. This applies on a `clk_b` edge for the A-to-B word and on a `clk_a` edge for the B-to-A word. The writer's flag stays low for at least one further writer edge and is high by the third writer edge.
- R5: A read leaves the stored word unchanged, so the same value can be read again.
- R6: After reset all four vacant flags read high.
- R7: When port B's outputs are driven, `b_dout` shows the A-to-B word if `b_mbx` is high and `fifo_q` if `b_mbx` is low.
- R8: When port A's outputs are driven, `a_dout` shows the B-to-A word regardless of `a_mbx`.
- R9: `a_oe` is high exactly when `a_cs_n` and `a_wr` are both low, and `b_oe` is high exactly when `b_cs_n` and `b_wr` are both low.
- R10: A store attempt is ignored when chip select is high, when enable is low, or when mailbox select is low. In each of these cases the flags and the stored words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A synchronous reset, active low |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_wr | input | 1 | Port A direction: 1 store, 0 read |
| a_en | input | 1 | Port A transfer enable |
| a_mbx | input | 1 | Port A mailbox select |
| a_din | input | DATA_W | Port A store data |
| a_dout | output | DATA_W | Port A output data (B-to-A word) |
| a_oe | output | 1 | Port A output enable |
| m1_vac_a | output | 1 | A-to-B word vacant, seen in clk_a domain |
| m2_vac_a | output | 1 | B-to-A word vacant, seen in clk_a domain |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B synchronous reset, active low |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_wr | input | 1 | Port B direction: 1 store, 0 read |
| b_en | input | 1 | Port B transfer enable |
| b_mbx | input | 1 | Port B mailbox select |
| b_din | input | DATA_W | Port B store data |
| fifo_q | input | DATA_W | Queue output word shown on port B when mailbox select is low |
| b_dout | output | DATA_W | Port B output data |
| b_oe | output | 1 | Port B output enable |
| m1_vac_b | output | 1 | A-to-B word vacant, seen in clk_b domain |
| m2_vac_b | output | 1 | B-to-A word vacant, seen in clk_b domain |

## Verification
The writer's own flag is due right after its store edge. The bench samples it at the next falling edge of that clock. The reader's view takes two or three reader edges, depending on clock phase. The bench checks it twice: once at the falling edge that follows the store, when it must still be high, and again after three full reader edges, when it must be low. The release back to the writer uses the same two-sample window. The data and enable outputs are combinational, so they are checked one nanosecond after the controls change, while enable is held low so that no clock edge can act on them.

// File: rtl/mbx_pkg.sv
// Shared types for the mailbox pair: the control bundle of one port.
package mbx_pkg;

    // One port's control inputs as sampled on its clock edge.
    typedef struct packed {
        logic cs_n;   // chip select, active low
        logic wr;     // 1 = store, 0 = read
        logic en;     // transfer enable
        logic mbx;    // mailbox select
    } mbx_ctl_t;

endpackage

// File: rtl/mbx_sync.sv
// Multi-flop synchronizer for one level signal.
// Assumes: d is driven from another clock domain and changes slowly
// (it is a toggle that flips at most once per handshake).
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the incoming level through STAGES flops.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_port_ctl.sv
// Decodes one port's controls into output enable and mailbox strobes.
// Assumes: controls are synchronous to the port clock; outputs are pure logic.
module mbx_port_ctl
    import mbx_pkg::*;
(
    input  mbx_ctl_t ctl,
    output logic     oe,
    output logic     mail_wr,
    output logic     mail_rd
);
    logic access;

    // A transfer happens only when selected and enabled.
    always_comb begin
        access  = !ctl.cs_n && ctl.en;
        oe      = !ctl.cs_n && !ctl.wr;
        mail_wr = access &&  ctl.wr && ctl.mbx;
        mail_rd = access && !ctl.wr && ctl.mbx;
    end
endmodule

// File: rtl/mbx_channel.sv
// One direction of the mailbox: a word register in the writer domain and
// a toggle handshake that tells each side whether the word is unread.
// Assumes: both resets are applied together; the reader only samples
// data_q while its own view shows unread mail, when data_q is frozen.
module mbx_channel #(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_w,
    input  logic              rst_w_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] data_q,
    output logic              vacant_w,
    input  logic              clk_r,
    input  logic              rst_r_n,
    input  logic              rd_req,
    output logic              vacant_r
);
    logic wr_tog, rd_tog;
    logic wr_tog_r, rd_tog_w;
    logic pend_w, pend_r;

    // Writer side: unread while its toggle differs from the returned one.
    assign pend_w   = wr_tog ^ rd_tog_w;
    assign vacant_w = !pend_w;

    // Writer: store the word and flip the toggle when the slot is vacant.
    always_ff @(posedge clk_w) begin
        if (!rst_w_n) begin
            wr_tog <= 1'b0;
            data_q <= '0;
        end else if (wr_req && !pend_w) begin
            wr_tog <= !wr_tog;
            data_q <= wr_data;
        end
    end

    // Carry the writer toggle into the reader domain.
    mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk  (clk_r),
        .rst_n(rst_r_n),
        .d    (wr_tog),
        .q    (wr_tog_r)
    );

    // Reader side: unread while the arrived toggle differs from its own.
    assign pend_r   = wr_tog_r ^ rd_tog;
    assign vacant_r = !pend_r;

    // Reader: acknowledge a read of unread mail by flipping its toggle.
    always_ff @(posedge clk_r) begin
        if (!rst_r_n)               rd_tog <= 1'b0;
        else if (rd_req && pend_r)  rd_tog <= !rd_tog;
    end

    // Carry the reader toggle back into the writer domain.
    mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk  (clk_w),
        .rst_n(rst_w_n),
        .d    (rd_tog),
        .q    (rd_tog_w)
    );

    // R1: an accepted store shows up in the word and marks it unread.
    a_r1_store_marks_full: assert property (@(posedge clk_w) disable iff (!rst_w_n)
        (wr_req && vacant_w) |=> (!vacant_w && data_q == $past(wr_data)));

    // R2: a store while unread leaves the word alone.
    a_r2_full_blocks_store: assert property (@(posedge clk_w) disable iff (!rst_w_n)
        (wr_req && !vacant_w) |=> $stable(data_q));

    // R3: unread mail at the reader stays unread until it is read.
    a_r3_pending_holds: assert property (@(posedge clk_r) disable iff (!rst_r_n)
        (!rd_req && !vacant_r) |=> !vacant_r);

    // R4: a read of unread mail frees the reader's view on the next cycle.
    a_r4_read_frees: assert property (@(posedge clk_r) disable iff (!rst_r_n)
        (rd_req && !vacant_r) |=> vacant_r);
endmodule

// File: rtl/mbx_pair.sv
// Two-way command mailbox between port A (clk_a) and port B (clk_b), with
// the port output selection and output-enable decode.
// Assumes: rst_a_n and rst_b_n are asserted together for several edges of
// both clocks; fifo_q comes from an external queue in the clk_b domain.
module mbx_pair
    import mbx_pkg::*;
#(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              rst_a_n,
    input  logic              a_cs_n,
    input  logic              a_wr,
    input  logic              a_en,
    input  logic              a_mbx,
    input  logic [DATA_W-1:0] a_din,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_oe,
    output logic              m1_vac_a,
    output logic              m2_vac_a,
    input  logic              clk_b,
    input  logic              rst_b_n,
    input  logic              b_cs_n,
    input  logic              b_wr,
    input  logic              b_en,
    input  logic              b_mbx,
    input  logic [DATA_W-1:0] b_din,
    input  logic [DATA_W-1:0] fifo_q,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_oe,
    output logic              m1_vac_b,
    output logic              m2_vac_b
);
    mbx_ctl_t          ctl_a, ctl_b;
    logic              a_mwr, a_mrd, b_mwr, b_mrd;
    logic [DATA_W-1:0] word_ab, word_ba;

    // Bundle each port's controls.
    assign ctl_a = '{cs_n: a_cs_n, wr: a_wr, en: a_en, mbx: a_mbx};
    assign ctl_b = '{cs_n: b_cs_n, wr: b_wr, en: b_en, mbx: b_mbx};

    mbx_port_ctl u_ctl_a (.ctl(ctl_a), .oe(a_oe), .mail_wr(a_mwr), .mail_rd(a_mrd));
    mbx_port_ctl u_ctl_b (.ctl(ctl_b), .oe(b_oe), .mail_wr(b_mwr), .mail_rd(b_mrd));

    // A-to-B word: stored at port A, read at port B.
    mbx_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ch_ab (
        .clk_w   (clk_a),
        .rst_w_n (rst_a_n),
        .wr_req  (a_mwr),
        .wr_data (a_din),
        .data_q  (word_ab),
        .vacant_w(m1_vac_a),
        .clk_r   (clk_b),
        .rst_r_n (rst_b_n),
        .rd_req  (b_mrd),
        .vacant_r(m1_vac_b)
    );

    // B-to-A word: stored at port B, read at port A.
    mbx_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ch_ba (
        .clk_w   (clk_b),
        .rst_w_n (rst_b_n),
        .wr_req  (b_mwr),
        .wr_data (b_din),
        .data_q  (word_ba),
        .vacant_w(m2_vac_b),
        .clk_r   (clk_a),
        .rst_r_n (rst_a_n),
        .rd_req  (a_mrd),
        .vacant_r(m2_vac_a)
    );

    // Output selection: port A always shows the B-to-A word.
    always_comb begin
        a_dout = word_ba;
        b_dout = b_mbx ? word_ab : fifo_q;
    end
endmodule

// File: tb/mbx_pair_test.sv
module mbx_pair_test;
    localparam int W = 36;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst_a_n, rst_b_n;
    logic a_cs_n, a_wr, a_en, a_mbx;
    logic b_cs_n, b_wr, b_en, b_mbx;
    logic [W-1:0] a_din, b_din, fifo_q;
    logic [W-1:0] a_dout, b_dout;
    logic a_oe, b_oe, m1_vac_a, m2_vac_a, m1_vac_b, m2_vac_b;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_ab = '0, exp_ba = '0;

    always #10 clk_a = !clk_a;
    initial begin
        #3;
        forever #13 clk_b = !clk_b;
    end

    mbx_pair uut (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .a_cs_n(a_cs_n), .a_wr(a_wr),
        .a_en(a_en), .a_mbx(a_mbx), .a_din(a_din), .a_dout(a_dout),
        .a_oe(a_oe), .m1_vac_a(m1_vac_a), .m2_vac_a(m2_vac_a),
        .clk_b(clk_b), .rst_b_n(rst_b_n), .b_cs_n(b_cs_n), .b_wr(b_wr),
        .b_en(b_en), .b_mbx(b_mbx), .b_din(b_din), .fifo_q(fifo_q),
        .b_dout(b_dout), .b_oe(b_oe), .m1_vac_b(m1_vac_b), .m2_vac_b(m2_vac_b)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One port-A transfer on the next rising clk_a edge; returns at the falling edge after.
    task automatic a_cycle(input bit cs_n, input bit wr, input bit en,
                           input bit mbx, input logic [W-1:0] d);
        @(negedge clk_a);
        a_cs_n = cs_n; a_wr = wr; a_en = en; a_mbx = mbx; a_din = d;
        @(negedge clk_a);
        a_cs_n = 1'b1; a_wr = 1'b0; a_en = 1'b0; a_mbx = 1'b0;
    endtask

    task automatic b_cycle(input bit cs_n, input bit wr, input bit en,
                           input bit mbx, input logic [W-1:0] d);
        @(negedge clk_b);
        b_cs_n = cs_n; b_wr = wr; b_en = en; b_mbx = mbx; b_din = d;
        @(negedge clk_b);
        b_cs_n = 1'b1; b_wr = 1'b0; b_en = 1'b0; b_mbx = 1'b0;
    endtask

    task automatic wait_a3(); repeat (3) @(posedge clk_a); #1; endtask
    task automatic wait_b3(); repeat (3) @(posedge clk_b); #1; endtask

    // Look at the A-to-B word through port B with enable low (no transfer).
    task automatic peek_ab(input string req);
        b_cs_n = 1'b0; b_wr = 1'b0; b_en = 1'b0; b_mbx = 1'b1; #1;
        check(b_dout == exp_ab, req, 64'(b_dout), 64'(exp_ab));
        b_cs_n = 1'b1; b_mbx = 1'b0;
    endtask

    task automatic peek_ba(input string req);
        a_cs_n = 1'b0; a_wr = 1'b0; a_en = 1'b0; a_mbx = 1'b0; #1;
        check(a_dout == exp_ba, req, 64'(a_dout), 64'(exp_ba));
        a_cs_n = 1'b1;
    endtask

    initial begin
        a_cs_n = 1'b1; a_wr = 1'b0; a_en = 1'b0; a_mbx = 1'b0; a_din = '0;
        b_cs_n = 1'b1; b_wr = 1'b0; b_en = 1'b0; b_mbx = 1'b0; b_din = '0;
        fifo_q = '0;
        rst_a_n = 1'b0; rst_b_n = 1'b0;
        repeat (6) @(posedge clk_b);
        #5; rst_a_n = 1'b1; rst_b_n = 1'b1;
        wait_a3(); wait_b3();
        // R6: all flags vacant after reset
        check(m1_vac_a && m1_vac_b && m2_vac_a && m2_vac_b, "R6",
              64'({m1_vac_a, m1_vac_b, m2_vac_a, m2_vac_b}), 64'hF);

        // A-to-B sweep over data patterns
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] d, d2;
            d  = 36'h9_1234_5670 ^ (W'(i) * 36'h1_0101_0101);
            d2 = ~d;
            a_cycle(1'b0, 1'b1, 1'b1, 1'b1, d);
            exp_ab = d;
            check(!m1_vac_a, "R1 writer flag after store", 64'(m1_vac_a), 0);
            check(m1_vac_b, "R3 reader view early", 64'(m1_vac_b), 1);
            a_cycle(1'b0, 1'b1, 1'b1, 1'b1, d2);
            wait_b3();
            check(!m1_vac_b, "R3 reader view by third edge", 64'(m1_vac_b), 0);
            peek_ab("R2 blocked store / R1 data");
            b_cycle(1'b0, 1'b0, 1'b1, 1'b1, '0);
            check(m1_vac_b, "R4 reader view after read", 64'(m1_vac_b), 1);
            check(!m1_vac_a, "R4 writer flag still low", 64'(m1_vac_a), 0);
            wait_a3();
            check(m1_vac_a, "R4 writer flag released", 64'(m1_vac_a), 1);
            peek_ab("R5 data kept after read");
        end

        // B-to-A sweep over data patterns
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] d, d2;
            d  = 36'h3_CAFE_0001 + (W'(i) * 36'h2_2222_2221);
            d2 = d ^ 36'hF_FFFF_0000;
            b_cycle(1'b0, 1'b1, 1'b1, 1'b1, d);
            exp_ba = d;
            check(!m2_vac_b, "R1 port B writer flag", 64'(m2_vac_b), 0);
            check(m2_vac_a, "R3 port A view early", 64'(m2_vac_a), 1);
            b_cycle(1'b0, 1'b1, 1'b1, 1'b1, d2);
            wait_a3();
            check(!m2_vac_a, "R3 port A view by third edge", 64'(m2_vac_a), 0);
            peek_ba("R2 blocked store / R1 data at A");
            a_cycle(1'b0, 1'b0, 1'b1, 1'b1, '0);
            check(m2_vac_a, "R4 port A view after read", 64'(m2_vac_a), 1);
            check(!m2_vac_b, "R4 port B flag still low", 64'(m2_vac_b), 0);
            wait_b3();
            check(m2_vac_b, "R4 port B flag released", 64'(m2_vac_b), 1);
            peek_ba("R5 B-to-A data kept after read");
        end

        // R10: store attempts that are not mailbox stores change nothing
        for (int c = 0; c < 8; c++) begin
            bit cs_n, en, mbx;
            cs_n = c[0]; en = c[1]; mbx = c[2];
            if (!cs_n && en && mbx) continue;
            a_cycle(cs_n, 1'b1, en, mbx, 36'h5_5555_5555);
            b_cycle(cs_n, 1'b1, en, mbx, 36'hA_AAAA_AAAA);
            check(m1_vac_a && m2_vac_b, "R10 flags unchanged",
                  64'({m1_vac_a, m2_vac_b}), 64'h3);
            peek_ab("R10 A-to-B word unchanged");
            peek_ba("R10 B-to-A word unchanged");
        end

        // R7 R8 R9: exhaustive sweep of the select inputs with enable low
        for (int c = 0; c < 8; c++) begin
            bit cs_n, wr, mbx;
            cs_n = c[0]; wr = c[1]; mbx = c[2];
            fifo_q = 36'h0_F0F0_0000 | W'(c * 7 + 1);
            b_cs_n = cs_n; b_wr = wr; b_mbx = mbx; b_en = 1'b0;
            a_cs_n = cs_n; a_wr = wr; a_mbx = mbx; a_en = 1'b0;
            #1;
            check(b_oe == (!cs_n && !wr), "R9 b_oe", 64'(b_oe), 64'(!cs_n && !wr));
            check(a_oe == (!cs_n && !wr), "R9 a_oe", 64'(a_oe), 64'(!cs_n && !wr));
            if (b_oe)
                check(b_dout == (mbx ? exp_ab : fifo_q), "R7 b_dout select",
                      64'(b_dout), 64'(mbx ? exp_ab : fifo_q));
            if (a_oe)
                check(a_dout == exp_ba, "R8 a_dout", 64'(a_dout), 64'(exp_ba));
        end
        b_cs_n = 1'b1; a_cs_n = 1'b1; a_mbx = 1'b0; b_mbx = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk_a);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule